// File: doc/BRIEF.md
# Split Transaction Responder Tracker

This block sits beside a slow memory or agent on a snooping bus. Each cycle it looks at the command and line address on the bus. When a coherent read targets a line this agent owns and the data cannot be supplied at once, the block splits the transaction. It asserts its split drive in the same cycle and records the line in a small pending table, together with the kind of response the line will need.

While a line is pending, any request from another master to that line is answered with wait. This keeps at most one split outstanding per line. A request also gets wait when a split is needed but the table has no free entry. Once the data for a pending entry is ready, the block raises a response request carrying the line address and the response command: shared for a split shared-read or read-for-invalidate, modified for a split read-for-modify. Pending responses are offered in the order their data became ready. The entry is released on the edge where the bus grants the response.

Top module: `split_tracker`

## Requirements
- R1: After reset (rst_ni low, asynchronous) the table is empty, and sr_o, wt_o and rsp_req_o are low. A line that was pending before the reset no longer draws wait.
- R2: A valid coherent read (command 1 shared read, 2 read-for-invalidate, 3 read-for-modify) with addr_own_i high, data_rdy_i low, no pending match and a free entry drives sr_o high in the same cycle. The line is stored in the lowest-index free entry at the next edge.
- R3: A coherent read that is not owned, or that is owned with data_rdy_i high, drives neither sr_o nor wt_o.
- R4: A valid request (commands 1 to 5; 4 is invalidate, 5 is write-invalidate) whose address matches a pending entry drives wt_o high and sr_o low in the same cycle.
- R5: Commands 0 (idle), 6 (shared response) and 7 (modified response), and any cycle with snp_valid_i low, drive neither sr_o nor wt_o.
- R6: When all entries are in use, a read that would otherwise be split drives wt_o high and sr_o low.
- R7: A pending entry split from command 1 or 2 is answered with rsp_cmd_o = 6. One split from command 3 is answered with rsp_cmd_o = 7. rsp_addr_o carries the pending line.
- R8: rdy_i[k] marks the data of entry k as ready. Responses are offered in the order of readiness. Entries that become ready in the same cycle go lowest index first.
- R9: rsp_req_o, rsp_cmd_o and rsp_addr_o hold until rsp_gnt_i is high at an edge. That edge frees the entry, so the line stops drawing wait and the entry can be reused.
- R10: When a grant and new readiness fall on the same edge, the newly ready entries queue behind every entry that remains ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| snp_valid_i | input | 1 | A bus command is present this cycle |
| snp_cmd_i | input | 3 | Observed command code |
| snp_addr_i | input | ADDR_W | Observed line address |
| addr_own_i | input | 1 | This agent is responsible for the line |
| data_rdy_i | input | 1 | Agent can answer the observed read at once |
| rdy_i | input | ENTRIES | Data ready, one bit per pending entry |
| rsp_gnt_i | input | 1 | Bus grants the offered response |
| sr_o | output | 1 | Split drive |
| wt_o | output | 1 | Wait drive |
| rsp_req_o | output | 1 | Response transaction requested |
| rsp_cmd_o | output | 3 | Response command code (6 or 7) |
| rsp_addr_o | output | ADDR_W | Line address of the response |

## Verification
Two functions meet in one cycle: release of a granted entry and admission of new work. The bench provokes both on the same edge. First it grants a response while a full table faces a split-worthy read; the read must still get wait, because the entry frees only at the edge. On the following cycle the same read must split into the freed index. The bench then grants while two entries become ready together. The new entries must queue behind the one entry that stays ready, with the lower index served first.

// File: rtl/split_tracker_pkg.sv
package split_tracker_pkg;
  localparam int unsigned CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_IDLE    = 3'd0,
    CMD_RD_SH   = 3'd1,
    CMD_RD_INV  = 3'd2,
    CMD_RD_MOD  = 3'd3,
    CMD_INVAL   = 3'd4,
    CMD_WR_INV  = 3'd5,
    CMD_RSP_SH  = 3'd6,
    CMD_RSP_MOD = 3'd7
  } bus_cmd_e;

  function automatic logic cmd_is_read(logic [CMD_W-1:0] c);
    return (c == CMD_RD_SH) || (c == CMD_RD_INV) || (c == CMD_RD_MOD);
  endfunction

  function automatic logic cmd_is_req(logic [CMD_W-1:0] c);
    return (c >= CMD_RD_SH) && (c <= CMD_WR_INV);
  endfunction
endpackage

// File: rtl/st_prio_enc.sv
module st_prio_enc #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/st_entry.sv
module st_entry #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned RANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mod_i,
  input  logic              rdy_i,
  input  logic [RANK_W-1:0] rank_i,
  input  logic              pop_i,
  input  logic              free_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              mod_o,
  output logic              ready_o,
  output logic              rise_o,
  output logic [RANK_W-1:0] rank_o
);
  logic              valid_q, mod_q, ready_q;
  logic [ADDR_W-1:0] addr_q;
  logic [RANK_W-1:0] rank_q;

  assign rise_o = valid_q && !ready_q && rdy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      mod_q   <= 1'b0;
      ready_q <= 1'b0;
      addr_q  <= '0;
      rank_q  <= '0;
    end else if (free_i) begin
      valid_q <= 1'b0;
      ready_q <= 1'b0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      ready_q <= 1'b0;
      addr_q  <= addr_i;
      mod_q   <= mod_i;
    end else if (rise_o) begin
      ready_q <= 1'b1;
      rank_q  <= rank_i;
    end else if (ready_q && pop_i) begin
      rank_q  <= rank_q - 1'b1;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign mod_o   = mod_q;
  assign ready_o = ready_q;
  assign rank_o  = rank_q;
endmodule

// File: rtl/split_tracker.sv
module split_tracker
  import split_tracker_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned ENTRIES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               snp_valid_i,
  input  logic [2:0]         snp_cmd_i,
  input  logic [ADDR_W-1:0]  snp_addr_i,
  input  logic               addr_own_i,
  input  logic               data_rdy_i,
  input  logic [ENTRIES-1:0] rdy_i,
  input  logic               rsp_gnt_i,
  output logic               sr_o,
  output logic               wt_o,
  output logic               rsp_req_o,
  output logic [2:0]         rsp_cmd_o,
  output logic [ADDR_W-1:0]  rsp_addr_o
);
  localparam int unsigned RANK_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]  ent_valid, ent_mod, ent_ready, ent_rise;
  logic [ENTRIES-1:0]  alloc, free_gnt, head, release_v;
  logic [ADDR_W-1:0]   ent_addr [ENTRIES];
  logic [RANK_W-1:0]   ent_rank [ENTRIES];
  logic [RANK_W-1:0]   rank_set [ENTRIES];
  logic                hit, full, need_split, pop, new_mod;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (ent_valid[i] && ent_addr[i] == snp_addr_i) hit = 1'b1;
  end

  assign full       = &ent_valid;
  assign need_split = snp_valid_i && cmd_is_read(snp_cmd_i) && addr_own_i && !data_rdy_i;
  assign sr_o       = need_split && !hit && !full;
  assign wt_o       = snp_valid_i && cmd_is_req(snp_cmd_i) && (hit || (need_split && full));
  assign new_mod    = (snp_cmd_i == CMD_RD_MOD);

  st_prio_enc #(.N(ENTRIES)) u_free_pick (
    .req_i (~ent_valid),
    .gnt_o (free_gnt)
  );

  assign alloc = free_gnt & {ENTRIES{sr_o}};
  assign pop   = rsp_req_o && rsp_gnt_i;

  // queue position for entries turning ready: after survivors, lower index first
  always_comb begin
    int acc;
    acc = 0;
    for (int i = 0; i < ENTRIES; i++) acc += int'(ent_ready[i]);
    if (pop) acc -= 1;
    for (int i = 0; i < ENTRIES; i++) begin
      rank_set[i] = RANK_W'(acc);
      if (ent_rise[i]) acc += 1;
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) head[i] = ent_ready[i] && (ent_rank[i] == '0);
  end

  assign release_v = head & {ENTRIES{pop}};

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_ent
      st_entry #(.ADDR_W(ADDR_W), .RANK_W(RANK_W)) u_ent (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .alloc_i (alloc[g]),
        .addr_i  (snp_addr_i),
        .mod_i   (new_mod),
        .rdy_i   (rdy_i[g]),
        .rank_i  (rank_set[g]),
        .pop_i   (pop),
        .free_i  (release_v[g]),
        .valid_o (ent_valid[g]),
        .addr_o  (ent_addr[g]),
        .mod_o   (ent_mod[g]),
        .ready_o (ent_ready[g]),
        .rise_o  (ent_rise[g]),
        .rank_o  (ent_rank[g])
      );
    end
  endgenerate

  always_comb begin
    logic mod_sel;
    mod_sel    = 1'b0;
    rsp_addr_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (head[i]) begin
        mod_sel    = mod_sel | ent_mod[i];
        rsp_addr_o = rsp_addr_o | ent_addr[i];
      end
    end
    rsp_req_o = |head;
    rsp_cmd_o = !rsp_req_o ? CMD_IDLE : (mod_sel ? CMD_RSP_MOD : CMD_RSP_SH);
  end
endmodule

// File: rtl/st_checker.sv
module st_checker
  import split_tracker_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned ENTRIES = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               snp_valid_i,
  input logic [2:0]         snp_cmd_i,
  input logic [ADDR_W-1:0]  snp_addr_i,
  input logic               addr_own_i,
  input logic               data_rdy_i,
  input logic               rsp_gnt_i,
  input logic               sr_o,
  input logic               wt_o,
  input logic               rsp_req_o,
  input logic [2:0]         rsp_cmd_o,
  input logic [ADDR_W-1:0]  rsp_addr_o,
  input logic [ENTRIES-1:0] head_i
);
  a_r4_sr_wt_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sr_o && wt_o));

  a_r2_split_needs_own: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_o |-> (snp_valid_i && addr_own_i && !data_rdy_i && cmd_is_read(snp_cmd_i)));

  a_r4_split_then_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_o |=> !(snp_valid_i && cmd_is_req(snp_cmd_i) &&
               snp_addr_i == $past(snp_addr_i) && !wt_o));

  a_r7_rsp_cmd_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_req_o |-> (rsp_cmd_o == CMD_RSP_SH || rsp_cmd_o == CMD_RSP_MOD));

  a_r8_single_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(head_i));

  a_r9_rsp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_req_o && !rsp_gnt_i) |=> (rsp_req_o && $stable(rsp_addr_o) && $stable(rsp_cmd_o)));

  a_r5_no_drive_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snp_valid_i |-> !(sr_o || wt_o));
endmodule

bind split_tracker st_checker #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .snp_valid_i (snp_valid_i),
  .snp_cmd_i   (snp_cmd_i),
  .snp_addr_i  (snp_addr_i),
  .addr_own_i  (addr_own_i),
  .data_rdy_i  (data_rdy_i),
  .rsp_gnt_i   (rsp_gnt_i),
  .sr_o        (sr_o),
  .wt_o        (wt_o),
  .rsp_req_o   (rsp_req_o),
  .rsp_cmd_o   (rsp_cmd_o),
  .rsp_addr_o  (rsp_addr_o),
  .head_i      (head)
);

// File: tb/split_tracker_tb_top.sv
module split_tracker_tb_top;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned ENTRIES = 4;

  logic               clk_i = 1'b0;
  logic               rst_ni;
  logic               snp_valid_i;
  logic [2:0]         snp_cmd_i;
  logic [ADDR_W-1:0]  snp_addr_i;
  logic               addr_own_i, data_rdy_i, rsp_gnt_i;
  logic [ENTRIES-1:0] rdy_i;
  logic               sr_o, wt_o, rsp_req_o;
  logic [2:0]         rsp_cmd_o;
  logic [ADDR_W-1:0]  rsp_addr_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  split_tracker #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) dut_i (.*);

  typedef struct packed {
    logic [3:0]  rq;
    logic        v;
    logic [2:0]  cmd;
    logic [15:0] addr;
    logic        own;
    logic        drdy;
    logic        exp_sr;
    logic        exp_wt;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{4'd2, 1'b1, 3'd1, 16'h0010, 1'b1, 1'b0, 1'b1, 1'b0}, // R2 split -> e0 shared
    '{4'd4, 1'b1, 3'd1, 16'h0010, 1'b1, 1'b0, 1'b0, 1'b1}, // R4 same line read
    '{4'd4, 1'b1, 3'd4, 16'h0010, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 invalidate
    '{4'd3, 1'b1, 3'd3, 16'h0020, 1'b1, 1'b1, 1'b0, 1'b0}, // R3 immediate
    '{4'd2, 1'b1, 3'd3, 16'h0020, 1'b1, 1'b0, 1'b1, 1'b0}, // R2 split -> e1 modified
    '{4'd3, 1'b1, 3'd1, 16'h0030, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 not owned
    '{4'd5, 1'b1, 3'd6, 16'h0010, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 response cmd
    '{4'd5, 1'b1, 3'd0, 16'h0010, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 idle cmd
    '{4'd5, 1'b0, 3'd1, 16'h0040, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 valid low
    '{4'd2, 1'b1, 3'd2, 16'h0040, 1'b1, 1'b0, 1'b1, 1'b0}, // R2 split -> e2 shared
    '{4'd4, 1'b1, 3'd5, 16'h0040, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 write-invalidate
    '{4'd2, 1'b1, 3'd1, 16'h0050, 1'b1, 1'b0, 1'b1, 1'b0}, // R2 split -> e3 shared
    '{4'd6, 1'b1, 3'd1, 16'h0060, 1'b1, 1'b0, 1'b0, 1'b1}, // R6 full
    '{4'd6, 1'b1, 3'd1, 16'h0060, 1'b1, 1'b1, 1'b0, 1'b0}, // R6 full but immediate
    '{4'd4, 1'b1, 3'd4, 16'h0060, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 no match
    '{4'd4, 1'b1, 3'd5, 16'h0020, 1'b0, 1'b0, 1'b0, 1'b1}  // R4 match e1
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic snoop(input logic v, input logic [2:0] c, input logic [15:0] a,
                       input logic own, input logic drdy);
    snp_valid_i = v; snp_cmd_i = c; snp_addr_i = a; addr_own_i = own; data_rdy_i = drdy;
  endtask

  task automatic rsp_chk(input string tag, input logic req, input logic [2:0] c,
                         input logic [15:0] a);
    chk({tag, " req"}, 32'(rsp_req_o), 32'(req));
    if (req) begin
      chk({tag, " cmd"}, 32'(rsp_cmd_o), 32'(c));
      chk({tag, " addr"}, 32'(rsp_addr_o), 32'(a));
    end
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; rdy_i = '0; rsp_gnt_i = 1'b0;
    snoop(1'b0, 3'd0, 16'h0, 1'b0, 1'b0);
    #2;
    chk("R1 reset sr", 32'(sr_o), 0);
    chk("R1 reset wt", 32'(wt_o), 0);
    chk("R1 reset rsp_req", 32'(rsp_req_o), 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    foreach (VECS[i]) begin
      @(negedge clk_i);
      snoop(VECS[i].v, VECS[i].cmd, VECS[i].addr, VECS[i].own, VECS[i].drdy);
      #2;
      chk($sformatf("R%0d row %0d sr", VECS[i].rq, i), 32'(sr_o), 32'(VECS[i].exp_sr));
      chk($sformatf("R%0d row %0d wt", VECS[i].rq, i), 32'(wt_o), 32'(VECS[i].exp_wt));
      chk($sformatf("R8 row %0d no rsp", i), 32'(rsp_req_o), 0);
    end

    // R8: entry 2 ready first
    @(negedge clk_i); snoop(1'b0, 3'd0, 16'h0, 1'b0, 1'b0); rdy_i = 4'b0100;
    #2 chk("R8 ready registered", 32'(rsp_req_o), 0);
    @(negedge clk_i); rdy_i = 4'b1010;
    #2 rsp_chk("R7 R8 first ready", 1'b1, 3'd6, 16'h0040);
    @(negedge clk_i); rdy_i = 4'b0000;
    #2 rsp_chk("R9 held without grant", 1'b1, 3'd6, 16'h0040);

    // R6 R9: grant while full, split-worthy read still waits
    @(negedge clk_i); rsp_gnt_i = 1'b1; snoop(1'b1, 3'd3, 16'h0070, 1'b1, 1'b0);
    #2;
    chk("R6 full during grant wt", 32'(wt_o), 1);
    chk("R6 full during grant sr", 32'(sr_o), 0);
    @(negedge clk_i); rsp_gnt_i = 1'b0; snoop(1'b1, 3'd5, 16'h0040, 1'b0, 1'b0);
    #2;
    chk("R9 freed line no wait", 32'(wt_o), 0);
    rsp_chk("R8 tie lowest index", 1'b1, 3'd7, 16'h0020);
    snoop(1'b1, 3'd3, 16'h0070, 1'b1, 1'b0);
    #1 chk("R9 reuse freed entry sr", 32'(sr_o), 1);

    // R10: grant of e1 together with e0 and e2 turning ready
    @(negedge clk_i); snoop(1'b1, 3'd5, 16'h0070, 1'b0, 1'b0); rsp_gnt_i = 1'b1; rdy_i = 4'b0101;
    #2 chk("R4 new entry wait", 32'(wt_o), 1);
    @(negedge clk_i); snoop(1'b0, 3'd0, 16'h0, 1'b0, 1'b0); rsp_gnt_i = 1'b0; rdy_i = '0;
    #2 rsp_chk("R10 survivor first", 1'b1, 3'd6, 16'h0050);
    @(negedge clk_i); rsp_gnt_i = 1'b1;
    #2 rsp_chk("R9 stable before edge", 1'b1, 3'd6, 16'h0050);
    @(negedge clk_i);
    #2 rsp_chk("R10 new ready low index", 1'b1, 3'd6, 16'h0010);
    @(negedge clk_i);
    #2 rsp_chk("R7 R10 modified response", 1'b1, 3'd7, 16'h0070);
    @(negedge clk_i); rsp_gnt_i = 1'b0; snoop(1'b1, 3'd1, 16'h0010, 1'b1, 1'b0);
    #2;
    rsp_chk("R9 table drained", 1'b0, 3'd0, 16'h0);
    chk("R9 drained line splits again", 32'(sr_o), 1);

    // R1: reset clears a pending line
    @(negedge clk_i); snoop(1'b0, 3'd0, 16'h0, 1'b0, 1'b0); rst_ni = 1'b0;
    #2 chk("R1 mid reset rsp_req", 32'(rsp_req_o), 0);
    @(negedge clk_i); rst_ni = 1'b1; snoop(1'b1, 3'd5, 16'h0010, 1'b0, 1'b0);
    #2 chk("R1 pending line cleared", 32'(wt_o), 0);

    @(negedge clk_i);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule